// File: doc/BRIEF.md
# BAR Access Dispatcher

This block sits behind the request decoder of a PCIe endpoint. Each clock it can accept one decoded memory request aimed at one of the function's base address registers. A request is either a read or a write of one DWORD. It carries a BAR index, a byte address and an opaque context tag; a write also carries data and four byte enables. The dispatcher steers the request to the back-end that owns that BAR. It then merges the read responses of all back-ends onto one response channel, which carries the read data and the tag that came with the request. A completion builder downstream turns these responses into completions.

There are three back-end kinds. BAR 0 maps to a 4 KB RAM of 1024 DWORDs with per-byte writes. BAR 1 maps to a responder that answers every read with the read address. Every other BAR maps to a sink that absorbs reads and writes and never answers. Every back-end that answers does so exactly two clocks after the request. This shared latency lets a plain AND-OR mux merge the responses without any arbitration.

Top module: `bar_dispatch`

## Requirements
- R1: While `rst` is high, and after it falls until a read has been accepted, `rsp_valid` is low.
- R2: A request is accepted on every clock where `req_valid` is high. Reads on back-to-back clocks give responses on back-to-back clocks, in request order.
- R3: A read with `req_bar`=0 returns the RAM word indexed by `req_addr[11:2]`, with `rsp_valid` high exactly two clocks after the read is accepted. Address bits above bit 11 and bits [1:0] do not affect which word is chosen.
- R4: A write with `req_bar`=0 replaces byte lane k of the addressed word (bits 8k+7:8k) only where `req_be[k]` is 1. A read on the next clock already sees the new value.
- R5: Reads ignore `req_be` and always return all 32 bits of the word.
- R6: A read with `req_bar`=1 returns the full request address as data, two clocks after the read is accepted.
- R7: Reads and writes with `req_bar` from 2 upward never produce a response and leave the RAM unchanged.
- R8: Every response carries on `rsp_ctx` the tag given with its read.
- R9: At most one back-end presents a valid response in a clock, and the output data comes from that back-end.
- R10: Writes never produce a response.
- R11: With `RAM_INIT`=1 the RAM word at index i starts as `RAM_SEED + i`; with `RAM_INIT`=0 it starts as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bar | input | BAR_W (3) | Target BAR index |
| req_addr | input | ADDR_W (32) | Byte address within the BAR |
| req_ctx | input | CTX_W (8) | Context tag, returned with read data |
| req_wdata | input | DATA_W (32) | Write data |
| req_be | input | DATA_W/8 (4) | Write byte enables |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | DATA_W (32) | Read data |
| rsp_ctx | output | CTX_W (8) | Context of the answered read |

## Verification
The bench builds the block with the default six BARs, 1024-word RAM, 32-bit address and 8-bit context. It sets `RAM_INIT`=1 with a nonzero seed, so every RAM word starts with a distinct known value and a read of a word never written still proves the index decode. Six BARs bring the four sink indices within reach, so the bench can check both silent drops and RAM isolation. The full 32-bit address lets the echo and address-aliasing cases use high address bits.

// File: rtl/bardisp_pkg.sv
package bardisp_pkg;

  typedef enum logic [1:0] {
    BK_RAM  = 2'd0,
    BK_ECHO = 2'd1,
    BK_NULL = 2'd2
  } bk_kind_e;

  // BAR-to-back-end assignment
  function automatic bk_kind_e kind_of(input int bar);
    if (bar == 0) return BK_RAM;
    if (bar == 1) return BK_ECHO;
    return BK_NULL;
  endfunction

endpackage

// File: rtl/bardisp_ram_be.sv
module bardisp_ram_be #(
  parameter int DATA_W    = 32,
  parameter int CTX_W     = 8,
  parameter int DEPTH     = 1024,
  parameter int RAM_INIT  = 0,
  parameter logic [DATA_W-1:0] RAM_SEED = '0,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int BE_W     = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [CTX_W-1:0]  ctx_in,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BE_W-1:0]   be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [CTX_W-1:0]  rsp_ctx
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic              vld_q;
  logic [CTX_W-1:0]  ctx_q;

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = (RAM_INIT != 0) ? RAM_SEED + DATA_W'(i) : '0;
  end

  // byte-lane write port
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < BE_W; k++)
        if (be[k]) mem[idx][k*8 +: 8] <= wdata[k*8 +: 8];
    end
  end

  // read port, registered twice
  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[idx];
    rsp_data <= rd_q;
    ctx_q    <= ctx_in;
    rsp_ctx  <= ctx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q     <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      vld_q     <= rd_en;
      rsp_valid <= vld_q;
    end
  end

  // R3: answer two clocks after each read
  a_r3_ram_latency: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> ##2 rsp_valid);
  // R8: tag follows the read through the pipeline
  a_r8_ram_ctx: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> ##2 (rsp_ctx == $past(ctx_in, 2)));
  // R10: a write is never answered
  a_r10_ram_wr_silent: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en) |-> ##2 !rsp_valid);

endmodule

// File: rtl/bardisp_echo_be.sv
module bardisp_echo_be #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int CTX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTX_W-1:0]  ctx_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [CTX_W-1:0]  rsp_ctx
);

  logic [DATA_W-1:0] d_q;
  logic [CTX_W-1:0]  ctx_q;
  logic              vld_q;

  always_ff @(posedge clk) begin
    if (rd_en) d_q <= DATA_W'(addr);
    rsp_data <= d_q;
    ctx_q    <= ctx_in;
    rsp_ctx  <= ctx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q     <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      vld_q     <= rd_en;
      rsp_valid <= vld_q;
    end
  end

  // R6: data is the address of the read two clocks back
  a_r6_echo_data: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> ##2 (rsp_valid && rsp_data == DATA_W'($past(addr, 2))));

endmodule

// File: rtl/bardisp_null_be.sv
module bardisp_null_be #(
  parameter int DATA_W = 32,
  parameter int CTX_W  = 8
) (
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [CTX_W-1:0]  rsp_ctx
);

  assign rsp_valid = 1'b0;
  assign rsp_data  = '0;
  assign rsp_ctx   = '0;

endmodule

// File: rtl/bar_dispatch.sv
module bar_dispatch #(
  parameter int NUM_BARS  = 6,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CTX_W     = 8,
  parameter int RAM_DEPTH = 1024,
  parameter int RAM_INIT  = 0,
  parameter logic [DATA_W-1:0] RAM_SEED = '0,
  localparam int BAR_W    = $clog2(NUM_BARS),
  localparam int BE_W     = DATA_W / 8,
  localparam int IDX_W    = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BAR_W-1:0]  req_bar,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [CTX_W-1:0]  rsp_ctx
);

  import bardisp_pkg::*;

  logic [NUM_BARS-1:0] bk_vld;
  logic [DATA_W-1:0]   bk_data [NUM_BARS];
  logic [CTX_W-1:0]    bk_ctx  [NUM_BARS];

  for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
    if (kind_of(b) == BK_RAM) begin : g_ram
      logic hit;
      assign hit = req_valid && (req_bar == BAR_W'(b));
      bardisp_ram_be #(
        .DATA_W(DATA_W), .CTX_W(CTX_W), .DEPTH(RAM_DEPTH),
        .RAM_INIT(RAM_INIT), .RAM_SEED(RAM_SEED)
      ) u_ram (
        .clk(clk), .rst(rst),
        .rd_en(hit && !req_write), .wr_en(hit && req_write),
        .idx(req_addr[IDX_W+1:2]), .ctx_in(req_ctx),
        .wdata(req_wdata), .be(req_be),
        .rsp_valid(bk_vld[b]), .rsp_data(bk_data[b]), .rsp_ctx(bk_ctx[b])
      );
    end else if (kind_of(b) == BK_ECHO) begin : g_echo
      logic hit;
      assign hit = req_valid && !req_write && (req_bar == BAR_W'(b));
      bardisp_echo_be #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTX_W(CTX_W)
      ) u_echo (
        .clk(clk), .rst(rst), .rd_en(hit), .addr(req_addr), .ctx_in(req_ctx),
        .rsp_valid(bk_vld[b]), .rsp_data(bk_data[b]), .rsp_ctx(bk_ctx[b])
      );
    end else begin : g_null
      bardisp_null_be #(.DATA_W(DATA_W), .CTX_W(CTX_W)) u_null (
        .rsp_valid(bk_vld[b]), .rsp_data(bk_data[b]), .rsp_ctx(bk_ctx[b])
      );
    end
  end

  // AND-OR merge: valid because every back-end shares one latency
  always_comb begin
    rsp_valid = |bk_vld;
    rsp_data  = '0;
    rsp_ctx   = '0;
    for (int b = 0; b < NUM_BARS; b++) begin
      rsp_data = rsp_data | (bk_data[b] & {DATA_W{bk_vld[b]}});
      rsp_ctx  = rsp_ctx  | (bk_ctx[b]  & {CTX_W{bk_vld[b]}});
    end
  end

  // R9: never two back-ends answering together
  a_r9_one_source: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bk_vld));
  // R7: a response only ever follows a read to an answering BAR
  a_r7_no_orphan: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write &&
                        kind_of(int'(req_bar)) != BK_NULL, 2));
  // R10: writes stay silent at the merged output
  a_r10_write_silent: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |-> ##2 !rsp_valid);
  // R1: nothing emerges straight out of reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> !rsp_valid);

endmodule

// File: tb/sim_bar_dispatch.sv
`timescale 1ns/1ps
module sim_bar_dispatch;

  localparam int NB = 6, AW = 32, DW = 32, CW = 8, DEPTH = 1024;
  localparam logic [31:0] SEED = 32'h5A00_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_bar = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [7:0]  req_ctx = '0;
  logic [3:0]  req_be = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [7:0]  rsp_ctx;

  always #2.5 clk = ~clk;

  bar_dispatch #(
    .NUM_BARS(NB), .ADDR_W(AW), .DATA_W(DW), .CTX_W(CW),
    .RAM_DEPTH(DEPTH), .RAM_INIT(1), .RAM_SEED(SEED)
  ) u0 (.*);

  typedef struct {
    logic [31:0] data;
    logic [7:0]  ctx;
    int          due;
    string       req;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] model [DEPTH];
  int cyc = 0, n_chk = 0, n_fail = 0, orphans = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares each response with the head of the scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb.size() == 0) begin
        orphans++;
        check(1'b0, "R7/R10 unexpected response", {32'd0, rsp_data}, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_data == e.data, e.req, {32'd0, rsp_data}, {32'd0, e.data});
        check(rsp_ctx == e.ctx, "R8 context", {56'd0, rsp_ctx}, {56'd0, e.ctx});
        check(cyc == e.due, "R2 response cycle", 64'(cyc), 64'(e.due));
      end
    end
  end

  // drive one request on the coming edge
  task automatic issue(input bit wr, input logic [2:0] bar, input logic [31:0] addr,
                       input logic [7:0] ctx, input logic [31:0] wd,
                       input logic [3:0] be, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_bar = bar; req_addr = addr;
    req_ctx = ctx; req_wdata = wd; req_be = be;
    if (!wr && bar == 3'd0)
      sb.push_back('{model[addr[11:2]], ctx, cyc + 2, req});
    else if (!wr && bar == 3'd1)
      sb.push_back('{addr, ctx, cyc + 2, req});
    else if (wr && bar == 3'd0)
      for (int k = 0; k < 4; k++)
        if (be[k]) model[addr[11:2]][k*8 +: 8] = wd[k*8 +: 8];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = SEED + 32'(i);
    repeat (4) begin
      @(negedge clk);
      check(rsp_valid == 1'b0, "R1 valid in reset", {63'd0, rsp_valid}, 64'd0);
    end
    rst = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(rsp_valid == 1'b0, "R1 valid after reset", {63'd0, rsp_valid}, 64'd0);
    end

    // R11: preloaded contents, R3 decode
    issue(0, 0, 32'h000, 8'h01, 0, 4'h0, "R11 preload word 0");
    issue(0, 0, 32'hFFC, 8'h02, 0, 4'h0, "R11 preload last word");
    issue(0, 0, 32'h1234_0047, 8'h03, 0, 4'hF, "R3 alias high and low bits");
    idle(3);

    // R4: byte lanes, read right after write
    issue(1, 0, 32'h010, 8'h00, 32'hDDCC_BBAA, 4'b0101, "R4 write");
    issue(0, 0, 32'h010, 8'h10, 0, 4'h0, "R4 partial write read-back");
    issue(1, 0, 32'h010, 8'h00, 32'h1122_3344, 4'b1000, "R4 write");
    issue(0, 0, 32'h012, 8'h11, 0, 4'h0, "R5 full word with zero byte enables");
    issue(1, 0, 32'h020, 8'h00, 32'hCAFE_F00D, 4'b1111, "R4 write");
    issue(0, 0, 32'h020, 8'h12, 0, 4'h3, "R4 full write read-back");
    issue(1, 0, 32'h024, 8'h00, 32'hFFFF_FFFF, 4'b0000, "R4 write");
    issue(0, 0, 32'h024, 8'h13, 0, 4'h0, "R4 no lanes enabled");
    idle(3);

    // R6: echo, including high address bits
    issue(0, 1, 32'h0000_0ABC, 8'h20, 0, 4'h0, "R6 echo low");
    issue(0, 1, 32'hDEAD_BEE4, 8'h21, 0, 4'h0, "R6 echo high");
    idle(3);

    // R7: sink BARs, writes must not reach RAM, nothing answers
    for (int b = 2; b < NB; b++) begin
      issue(0, 3'(b), 32'h030, 8'h30, 0, 4'h0, "R7 null read");
      issue(1, 3'(b), 32'h030, 8'h31, 32'h0BAD_0BAD, 4'hF, "R7 null write");
    end
    issue(1, 1, 32'h030, 8'h32, 32'h0BAD_0BAD, 4'hF, "R10 echo write");
    idle(4);
    check(orphans == 0, "R7 no response from sink", 64'(orphans), 64'd0);
    issue(0, 0, 32'h030, 8'h33, 0, 4'h0, "R7 RAM untouched by sink writes");
    idle(3);

    // R2/R9: back-to-back mixed reads interleaved between back-ends
    for (int i = 0; i < 16; i++) begin
      if (i % 3 == 2)
        issue(0, 3'd1, 32'h8000_0000 | 32'(i * 4), 8'(8'h40 + i), 0, 4'h0, "R9 mux echo");
      else if (i % 5 == 4)
        issue(0, 3'd4, 32'(i * 4), 8'(8'h40 + i), 0, 4'h0, "R7 null in stream");
      else
        issue(0, 3'd0, 32'(i * 4 + 32'h100), 8'(8'h40 + i), 0, 4'h0, "R9 mux RAM");
    end
    idle(5);

    check(sb.size() == 0, "R2 all reads answered", 64'(sb.size()), 64'd0);
    finish_run();
  end

endmodule